// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block is the device-side sequencer of a clocked burst read port: a 19-bit address, a 32-bit data word. An external burst clock is brought into the system clock domain. A configuration pin picks its rising or its falling transition as the active edge. On an active edge with the latch strobe low, the block loads a start address. It then waits a fixed number of active edges of first-access latency. After that, each active edge with the advance strobe low steps the internal burst address by one. The data word for the current burst address comes from a small registered array model.

The shared data bus can be handed to another device mid-burst. Raising both output enable and advance suspends the burst: the bus is released and the burst address holds. Lowering output enable again resumes the burst at the held address. Raising chip enable, or pulling the power-down input low, aborts the burst. A separate output-disable input releases the bus whatever output enable does. A second configuration pin makes the ready flag lead the first valid word by one active edge.

Top module: `sbr_read_ctrl`

## Requirements
- R1: After reset the data bus is released (dq_oe = 0) and rdy is low.
- R2: On an active edge with ce_n = 0, pd_n = 1 and lat_n = 0, the burst address loads from addr_in and a burst begins. Whenever the bus is driven, dq_out carries the word for the current burst address A: bits [18:0] = A and bits [31:19] = ~A[12:0].
- R3: After the latch edge the burst waits FIRST_LAT further active edges, during which the address does not step. With cfg_rdy_early = 0, rdy rises on the edge that ends the wait.
- R4: Once the wait is over, each active edge with adv_n = 0 increments the burst address by exactly one. No change happens between active edges.
- R5: An active edge with adv_n = 1 and oe_n = 0 leaves the burst address unchanged, and the same word stays driven on the bus.
- R6: With oe_n = 1 and adv_n = 1 the burst is suspended: the bus is released and the address holds. Lowering oe_n resumes output at the held word, and further advances continue from it.
- R7: With oe_n = 1 and adv_n = 0 the bus is released, but the burst address still increments on each active edge.
- R8: ce_n = 1 or pd_n = 0 at an active edge aborts the burst. The bus is released, rdy falls, and no further advance occurs until a new latch. pd_n = 0 releases the bus at once.
- R9: dis_n = 0 releases the bus whatever oe_n is, and leaves the burst address untouched.
- R10: cfg_fall_edge = 0 makes the rising burst-clock transition the active edge. cfg_fall_edge = 1 makes the falling transition active, and rising transitions then have no effect.
- R11: With cfg_rdy_early = 1, rdy rises one active edge before the wait ends.
- R12: The burst address wraps from 2^19 - 1 to 0.
- R13: While the bus is released, dq_out reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Burst clock, sampled into the clk domain |
| cfg_fall_edge | input | 1 | 1: falling bclk transition is the active edge |
| cfg_rdy_early | input | 1 | 1: rdy leads the first valid word by one active edge |
| ce_n | input | 1 | Chip enable, active low |
| pd_n | input | 1 | Reset/power-down, active low, aborts the burst |
| lat_n | input | 1 | Address latch strobe, active low |
| adv_n | input | 1 | Burst address advance, active low |
| oe_n | input | 1 | Output enable, active low |
| dis_n | input | 1 | Output disable, active low |
| addr_in | input | 19 | Start address |
| dq_out | output | 32 | Data word |
| dq_oe | output | 1 | Data bus drive enable |
| rdy | output | 1 | Valid-data-ready flag |

## Verification
The bench uses the default parameters: ADDR_W = 19, DATA_W = 32, FIRST_LAT = 2 and two synchronizer stages. With these values the two-edge latency is long enough to observe the early and the normal ready positions as different edges. A start address two below the top of the 19-bit space reaches the wrap within three advances. Each burst-clock half period spans six system clocks, so every active edge has fully propagated through the synchronizer before the bench samples the outputs.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_WAIT = 2'd1,
    BST_RUN  = 2'd2
  } bst_e;

  typedef struct packed {
    logic ce_n;
    logic pd_n;
    logic lat_n;
    logic adv_n;
  } bus_ctl_t;

endpackage

// File: rtl/sbr_edge_det.sv
module sbr_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fall_sel,
  output logic tick
);

  localparam int CHAIN_W = SYNC_N + 1;

  logic [CHAIN_W-1:0] sh_q;
  logic [CHAIN_W-1:0] sh_d;
  logic               lvl_new;
  logic               lvl_old;

  always_comb begin
    sh_d = {sh_q[CHAIN_W-2:0], bclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign lvl_new = sh_q[CHAIN_W-2];
  assign lvl_old = sh_q[CHAIN_W-1];

  // one system-clock pulse per selected burst-clock transition
  always_comb begin
    if (fall_sel) begin
      tick = lvl_old & ~lvl_new;
    end else begin
      tick = lvl_new & ~lvl_old;
    end
  end

endmodule

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq
  import sbr_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int FIRST_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  bus_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rdy_early,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              active,
  output logic              run,
  output logic              rdy
);

  localparam int WAIT_W = (FIRST_LAT < 1) ? 1 : $clog2(FIRST_LAT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(FIRST_LAT);
  localparam logic [WAIT_W-1:0] WAIT_ONE  = WAIT_W'(1);
  localparam bst_e LATCH_ST = (FIRST_LAT == 0) ? BST_RUN : BST_WAIT;

  bst_e              st_q, st_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [ADDR_W-1:0] addr_d;
  logic              abort_req;

  assign abort_req = ctl.ce_n | ~ctl.pd_n;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    addr_d = addr_q;
    if (tick) begin
      if (abort_req) begin
        st_d   = BST_IDLE;
        wait_d = '0;
      end else if (!ctl.lat_n) begin
        st_d   = LATCH_ST;
        wait_d = WAIT_LOAD;
        addr_d = addr_in;
      end else begin
        unique case (st_q)
          BST_WAIT: begin
            wait_d = wait_q - WAIT_ONE;
            if (wait_q == WAIT_ONE) begin
              st_d = BST_RUN;
            end
          end
          BST_RUN: begin
            if (!ctl.adv_n) begin
              addr_d = addr_q + ADDR_W'(1);
            end
          end
          default: begin
            st_d = BST_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BST_IDLE;
      wait_q <= '0;
      addr_q <= '0;
    end else if (tick) begin
      st_q   <= st_d;
      wait_q <= wait_d;
      addr_q <= addr_d;
    end
  end

  assign addr_nxt = addr_d;
  assign active   = (st_q != BST_IDLE);
  assign run      = (st_q == BST_RUN);
  assign rdy      = run | (rdy_early & (st_q == BST_WAIT) & (wait_q == WAIT_ONE));

endmodule

// File: rtl/sbr_word_model.sv
module sbr_word_model #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data_q
);

  logic [DATA_W-1:0] data_d;

  // low bits carry the address, upper bits its complement, repeating
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (i < ADDR_W) begin
        data_d[i] = addr[i];
      end else begin
        data_d[i] = ~addr[(i - ADDR_W) % ADDR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/sbr_read_ctrl.sv
module sbr_read_ctrl
  import sbr_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 32,
  parameter int FIRST_LAT = 2,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              cfg_fall_edge,
  input  logic              cfg_rdy_early,
  input  logic              ce_n,
  input  logic              pd_n,
  input  logic              lat_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic              dis_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rdy
);

  logic              edge_tick;
  bus_ctl_t          ctl;
  logic [ADDR_W-1:0] burst_addr;
  logic [ADDR_W-1:0] burst_addr_nxt;
  logic              burst_active;
  logic              burst_run;
  logic              seq_rdy;
  logic [DATA_W-1:0] word_q;
  logic              drive_en;

  assign ctl = '{ce_n: ce_n, pd_n: pd_n, lat_n: lat_n, adv_n: adv_n};

  sbr_edge_det #(.SYNC_N(SYNC_N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .fall_sel (cfg_fall_edge),
    .tick     (edge_tick)
  );

  sbr_burst_seq #(.ADDR_W(ADDR_W), .FIRST_LAT(FIRST_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (edge_tick),
    .ctl       (ctl),
    .addr_in   (addr_in),
    .rdy_early (cfg_rdy_early),
    .addr_q    (burst_addr),
    .addr_nxt  (burst_addr_nxt),
    .active    (burst_active),
    .run       (burst_run),
    .rdy       (seq_rdy)
  );

  sbr_word_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (edge_tick),
    .addr   (burst_addr_nxt),
    .data_q (word_q)
  );

  // bus is driven only inside a live burst with every enable granted
  assign drive_en = burst_active & ~ce_n & pd_n & ~oe_n & dis_n;
  assign dq_oe    = drive_en;
  assign dq_out   = drive_en ? word_q : '0;
  assign rdy      = seq_rdy & ~ce_n & pd_n;

endmodule

// File: rtl/sbr_read_ctrl_chk.sv
module sbr_read_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              ce_n,
  input logic              pd_n,
  input logic              lat_n,
  input logic              adv_n,
  input logic              dis_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_q,
  input logic              run,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              rdy
);

  function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) begin
      w[i] = (i < ADDR_W) ? a[i] : ~a[(i - ADDR_W) % ADDR_W];
    end
    return w;
  endfunction

  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ce_n && pd_n && !lat_n) |=> (addr_q == $past(addr_in))); // R2

  AST_WORD_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dq_out == exp_word(addr_q))); // R2

  AST_QUIET_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(addr_q)); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && lat_n && !adv_n && !ce_n && pd_n)
      |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1)))); // R4

  AST_ADV_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lat_n && adv_n) |=> $stable(addr_q)); // R5

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (ce_n || !pd_n)) |=> (!rdy && !dq_oe)); // R8

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |-> (!dq_oe && dq_out == '0)); // R9

endmodule

bind sbr_read_ctrl sbr_read_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (edge_tick),
  .ce_n    (ce_n),
  .pd_n    (pd_n),
  .lat_n   (lat_n),
  .adv_n   (adv_n),
  .dis_n   (dis_n),
  .addr_in (addr_in),
  .addr_q  (burst_addr),
  .run     (burst_run),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe),
  .rdy     (rdy)
);

// File: tb/sbr_read_ctrl_test.sv
module sbr_read_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        bclk;
  logic        cfg_fall_edge;
  logic        cfg_rdy_early;
  logic        ce_n, pd_n, lat_n, adv_n, oe_n, dis_n;
  logic [18:0] addr_in;
  logic [31:0] dq_out;
  logic        dq_oe;
  logic        rdy;

  int checks = 0;
  int errors = 0;
  logic [18:0] exp_a;

  sbr_read_ctrl uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk          (bclk),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_rdy_early (cfg_rdy_early),
    .ce_n          (ce_n),
    .pd_n          (pd_n),
    .lat_n         (lat_n),
    .adv_n         (adv_n),
    .oe_n          (oe_n),
    .dis_n         (dis_n),
    .addr_in       (addr_in),
    .dq_out        (dq_out),
    .dq_oe         (dq_oe),
    .rdy           (rdy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [18:0] a);
    return {~a[12:0], a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic fall, input logic early);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0;
    cfg_fall_edge = fall; cfg_rdy_early = early;
    ce_n = 1'b1; pd_n = 1'b1; lat_n = 1'b1; adv_n = 1'b1;
    oe_n = 1'b1; dis_n = 1'b1; addr_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    bclk = 1'b1;
    repeat (6) @(negedge clk);
    bclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic latch_and_wait(input logic [18:0] a);
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b1; lat_n = 1'b0; addr_in = a;
    pulse();
    lat_n = 1'b1;
    pulse();
    pulse();
    exp_a = a;
  endtask

  task automatic t_reset();
    apply_reset(1'b0, 1'b0);
    check("R1 dq_oe", {31'b0, dq_oe}, 32'd0);
    check("R1 rdy", {31'b0, rdy}, 32'd0);
  endtask

  task automatic t_stream();
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b1; lat_n = 1'b0; addr_in = 19'h01234;
    pulse();
    lat_n = 1'b1;
    exp_a = 19'h01234;
    check("R2 dq_oe after latch", {31'b0, dq_oe}, 32'd1);
    check("R2 word after latch", dq_out, word_of(exp_a));
    check("R3 rdy low at latch", {31'b0, rdy}, 32'd0);
    adv_n = 1'b0;
    pulse();
    check("R3 rdy low one edge in", {31'b0, rdy}, 32'd0);
    check("R3 no step during wait", dq_out, word_of(exp_a));
    pulse();
    check("R3 rdy at end of wait", {31'b0, rdy}, 32'd1);
    check("R3 still first word", dq_out, word_of(exp_a));
    for (int i = 0; i < 4; i++) begin
      pulse();
      exp_a = exp_a + 19'd1;
      check("R4 advance word", dq_out, word_of(exp_a));
    end
  endtask

  task automatic t_hold();
    adv_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pulse();
      check("R5 held word", dq_out, word_of(exp_a));
      check("R5 still driven", {31'b0, dq_oe}, 32'd1);
    end
  endtask

  task automatic t_suspend();
    adv_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    check("R6 released on suspend", {31'b0, dq_oe}, 32'd0);
    check("R13 zero when released", dq_out, 32'd0);
    pulse();
    pulse();
    oe_n = 1'b0;
    @(negedge clk);
    check("R6 resume held word", dq_out, word_of(exp_a));
    adv_n = 1'b0;
    pulse();
    exp_a = exp_a + 19'd1;
    check("R6 continue after resume", dq_out, word_of(exp_a));
  endtask

  task automatic t_oe_high_advance();
    oe_n = 1'b1; adv_n = 1'b0;
    pulse();
    pulse();
    exp_a = exp_a + 19'd2;
    check("R7 released while advancing", {31'b0, dq_oe}, 32'd0);
    adv_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R7 counter moved", dq_out, word_of(exp_a));
  endtask

  task automatic t_disable();
    dis_n = 1'b0;
    @(negedge clk);
    check("R9 released by disable", {31'b0, dq_oe}, 32'd0);
    check("R13 zero under disable", dq_out, 32'd0);
    pulse();
    dis_n = 1'b1;
    @(negedge clk);
    check("R9 address untouched", dq_out, word_of(exp_a));
  endtask

  task automatic t_abort_ce();
    adv_n = 1'b0; ce_n = 1'b1;
    pulse();
    check("R8 ce abort dq_oe", {31'b0, dq_oe}, 32'd0);
    check("R8 ce abort rdy", {31'b0, rdy}, 32'd0);
    ce_n = 1'b0;
    pulse();
    pulse();
    check("R8 no resume without latch", {31'b0, dq_oe}, 32'd0);
    check("R8 rdy stays low", {31'b0, rdy}, 32'd0);
  endtask

  task automatic t_abort_pd();
    latch_and_wait(19'h2A5A5);
    check("R8 pd setup driven", dq_out, word_of(exp_a));
    pd_n = 1'b0;
    @(negedge clk);
    check("R8 pd releases at once", {31'b0, dq_oe}, 32'd0);
    adv_n = 1'b0;
    pulse();
    pd_n = 1'b1;
    @(negedge clk);
    check("R8 pd abort dq_oe", {31'b0, dq_oe}, 32'd0);
    check("R8 pd abort rdy", {31'b0, rdy}, 32'd0);
    adv_n = 1'b1;
  endtask

  task automatic t_wrap();
    latch_and_wait(19'h7FFFE);
    adv_n = 1'b0;
    pulse();
    check("R12 top word", dq_out, word_of(19'h7FFFF));
    pulse();
    check("R12 wrapped to zero", dq_out, word_of(19'h00000));
    pulse();
    check("R12 after wrap", dq_out, word_of(19'h00001));
    adv_n = 1'b1;
  endtask

  task automatic t_fall_edge();
    apply_reset(1'b1, 1'b0);
    ce_n = 1'b0; oe_n = 1'b0; lat_n = 1'b0; addr_in = 19'h0BEEF;
    bclk = 1'b1;
    repeat (8) @(negedge clk);
    check("R10 rising ignored", {31'b0, dq_oe}, 32'd0);
    bclk = 1'b0;
    repeat (8) @(negedge clk);
    check("R10 falling latches", {31'b0, dq_oe}, 32'd1);
    check("R10 falling word", dq_out, word_of(19'h0BEEF));
    lat_n = 1'b1;
  endtask

  task automatic t_early();
    apply_reset(1'b0, 1'b1);
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b1; lat_n = 1'b0; addr_in = 19'h13579;
    pulse();
    lat_n = 1'b1;
    check("R11 rdy low at latch", {31'b0, rdy}, 32'd0);
    pulse();
    check("R11 rdy one edge early", {31'b0, rdy}, 32'd1);
    pulse();
    check("R11 rdy stays high", {31'b0, rdy}, 32'd1);
    check("R11 first word", dq_out, word_of(19'h13579));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_hold();
    t_suspend();
    t_oe_high_advance();
    t_disable();
    t_abort_ce();
    t_abort_pd();
    t_wrap();
    t_fall_edge();
    t_early();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule